// File: doc/BRIEF.md
# LIN Frame Checksum Unit

This block forms and verifies the checksum that closes a LIN response. Bytes come in on a plain stream made of a valid strobe, a byte and a last-byte marker. A frame-start pulse opens each frame and fixes two things for it: whether the protected identifier counts in the sum (enhanced) or does not (classic), and whether the frame is being sent or received. Both kinds of frame share one accumulator. It adds 8-bit values and folds the carry out of the top bit back into bit 0.

When sending, every streamed byte is a data byte. One cycle after the last one is taken, the unit gives the inverted sum as the checksum byte. When receiving, the byte marked last is the checksum from the wire. The unit tests that byte for exact equality with the inverted sum of the bytes before it, then pulses pass or fail. It never adds the received byte into the sum and tests the total for all-ones. That shortcut would wrongly accept 0xFF when the true checksum is 0x00.

A frame with a data-byte count outside 1..MAX_BYTES gets a length-error pulse in place of a checksum result.

Top module: `lin_cksum_unit`

## Requirements
- R1: After reset, cks_vld_o, pass_o, fail_o and len_err_o are 0 and cks_o is 0x00.
- R2: The sum adds each byte modulo 256 and adds any carry out of bit 7 back into bit 0. For example, 0xF0 plus 0x20 gives 0x11.
- R3: In transmit mode (rx_dir_i=0 at start), cks_vld_o pulses for one cycle in the cycle after the last data byte is accepted. In that cycle cks_o holds the bitwise inverse of the final sum, and cks_o keeps that value until the next transmit result.
- R4: If enh_mode_i=1 at frame start, pid_i is the first addend. If enh_mode_i=0, only data bytes are summed.
- R5: In receive mode (rx_dir_i=1 at start), the byte marked last is the received checksum. pass_o pulses in the cycle after it is accepted when it equals the inverse of the sum of the preceding bytes.
- R6: In receive mode any other received checksum makes fail_o pulse instead. This includes a received 0xFF when the sum is 0xFF (expected checksum 0x00).
- R7: len_err_o pulses in place of any other result in three cases: a receive frame with zero data bytes, a receive frame with more than MAX_BYTES (default 8) data bytes, and a transmit frame with more than MAX_BYTES data bytes.
- R8: enh_mode_i, rx_dir_i and pid_i are sampled only in a cycle with frame_start_i=1. Changes at other times have no effect on the frame in progress.
- R9: Bytes presented when no frame is open (before any start, or after the last byte of a frame) are ignored and produce no result.
- R10: A byte valid in the same cycle as frame_start_i is the first byte of the new frame. A start inside an open frame discards it and begins again. At most one result output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Opens a frame; samples mode, direction and identifier |
| enh_mode_i | input | 1 | 1 = enhanced (identifier included), 0 = classic |
| rx_dir_i | input | 1 | 1 = receive and check, 0 = transmit and generate |
| pid_i | input | W | Protected identifier, used in enhanced mode |
| byte_vld_i | input | 1 | Byte strobe |
| byte_last_i | input | 1 | Marks the final byte of the frame |
| byte_i | input | W | Streamed byte |
| cks_o | output | W | Generated checksum (transmit) |
| cks_vld_o | output | 1 | One-cycle pulse: cks_o is new |
| pass_o | output | 1 | One-cycle pulse: received checksum correct |
| fail_o | output | 1 | One-cycle pulse: received checksum wrong |
| len_err_o | output | 1 | One-cycle pulse: data-byte count out of range |

## Verification
Two events can share a cycle: a frame start and the first byte, or a frame start and the last byte of a single-byte transmit frame. In that cycle the accumulator must take its base from the new frame's mode and identifier and add the byte to it. The bench drives both forms, and also starts that land inside an open frame. A behavioural model that re-derives the sum from a byte list judges every cycle. Directed frames cover the carry fold, the all-ones sum with a received 0xFF, and the length limits.

// File: rtl/lin_cksum_pkg.sv
package lin_cksum_pkg;

   // Result selected for the cycle after a frame closes
   typedef enum logic [2:0] {
      RES_IDLE   = 3'd0,
      RES_TXCK   = 3'd1,
      RES_PASS   = 3'd2,
      RES_FAIL   = 3'd3,
      RES_LENERR = 3'd4
   } res_e;

   // Carry-fold adder implementation choices
   localparam int FOLD_RIPPLE = 0;
   localparam int FOLD_CSEL   = 1;

endpackage

// File: rtl/lin_cks_add.sv
module lin_cks_add #(
   parameter int W        = 8,
   parameter int FOLD_SEL = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);
   import lin_cksum_pkg::*;

   if (W < 2) begin : g_bad_w
      $error("lin_cks_add: W must be at least 2");
   end
   if (FOLD_SEL != FOLD_RIPPLE && FOLD_SEL != FOLD_CSEL) begin : g_bad_sel
      $error("lin_cks_add: unknown FOLD_SEL");
   end

   logic [W:0] raw_sum;
   assign raw_sum = {1'b0, a_i} + {1'b0, b_i};

   if (FOLD_SEL == FOLD_RIPPLE) begin : g_ripple
      // second add of the carry; cannot carry out again
      assign y_o = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};
   end else begin : g_csel
      logic [W:0] inc_sum;
      assign inc_sum = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(1);
      assign y_o     = raw_sum[W] ? inc_sum[W-1:0] : raw_sum[W-1:0];
   end

endmodule

// File: rtl/lin_cks_ctl.sv
module lin_cks_ctl #(
   parameter int MAX_BYTES = 8,
   parameter int CNT_W     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic rx_i,
   input  logic vld_i,
   input  logic last_i,
   output logic add_en_o,
   output logic fin_o,
   output logic rx_eff_o,
   output logic len_bad_o
);

   if (MAX_BYTES < 1) begin : g_bad_max
      $error("lin_cks_ctl: MAX_BYTES must be at least 1");
   end
   if ((1 << CNT_W) < MAX_BYTES + 2) begin : g_bad_cnt
      $error("lin_cks_ctl: CNT_W too small for MAX_BYTES");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BYTES);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BYTES + 1);

   logic             open_q;
   logic             rx_q;
   logic [CNT_W-1:0] cnt_q;

   logic             take;
   logic             is_ck;
   logic [CNT_W-1:0] cnt_base;
   logic [CNT_W-1:0] cnt_next;

   assign take     = vld_i & (open_q | start_i);
   assign rx_eff_o = start_i ? rx_i : rx_q;
   assign cnt_base = start_i ? '0 : cnt_q;
   assign is_ck    = take & last_i & rx_eff_o;
   assign add_en_o = take & ~is_ck;
   assign fin_o    = take & last_i;

   always_comb begin
      cnt_next = cnt_base;
      if (add_en_o && cnt_base != CNT_SAT) begin
         cnt_next = cnt_base + CNT_W'(1);
      end
   end

   always_comb begin
      if (is_ck) begin
         len_bad_o = (cnt_base == '0) || (cnt_base > CNT_MAX);
      end else begin
         len_bad_o = (cnt_next > CNT_MAX);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         rx_q   <= 1'b0;
         cnt_q  <= '0;
      end else begin
         if (fin_o) begin
            open_q <= 1'b0;
         end else if (start_i) begin
            open_q <= 1'b1;
         end
         if (start_i) begin
            rx_q <= rx_i;
         end
         if (start_i || add_en_o) begin
            cnt_q <= cnt_next;
         end
      end
   end

   // R9: a closing byte leaves no frame open
   p_fin_closes_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !open_q);

   // R8: direction held while a frame runs without a new start
   p_dir_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !start_i) |=> $stable(rx_q));

   // R7: count never runs past the saturation marker
   p_cnt_sat_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_SAT && !start_i) |=> (cnt_q == CNT_SAT));

endmodule

// File: rtl/lin_cks_accum.sv
module lin_cks_accum #(
   parameter int W        = 8,
   parameter int FOLD_SEL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         enh_i,
   input  logic [W-1:0] pid_i,
   input  logic         add_en_i,
   input  logic [W-1:0] byte_i,
   output logic [W-1:0] acc_base_o,
   output logic [W-1:0] sum_add_o
);

   logic [W-1:0] acc_q;

   assign acc_base_o = start_i ? (enh_i ? pid_i : '0) : acc_q;

   lin_cks_add #(
      .W        (W),
      .FOLD_SEL (FOLD_SEL)
   ) u_add (
      .a_i (acc_base_o),
      .b_i (byte_i),
      .y_o (sum_add_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (add_en_i) begin
         acc_q <= sum_add_o;
      end else if (start_i) begin
         acc_q <= acc_base_o;
      end
   end

   // R4: a bare start seeds the sum with the identifier or zero
   p_start_seed_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !add_en_i) |=> (acc_q == $past(enh_i ? pid_i : '0)));

   // R2: adding zero never changes the held sum
   p_zero_add_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (add_en_i && !start_i && byte_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/lin_cks_result.sv
module lin_cks_result #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fin_i,
   input  logic         rx_i,
   input  logic         len_bad_i,
   input  logic [W-1:0] acc_base_i,
   input  logic [W-1:0] sum_add_i,
   input  logic [W-1:0] byte_i,
   output logic [W-1:0] cks_o,
   output logic         cks_vld_o,
   output logic         pass_o,
   output logic         fail_o,
   output logic         len_err_o
);
   import lin_cksum_pkg::*;

   res_e res;

   always_comb begin
      res = RES_IDLE;
      if (fin_i) begin
         if (len_bad_i) begin
            res = RES_LENERR;
         end else if (rx_i) begin
            // exact match against the inverted sum, never sum+byte==all-ones
            res = (byte_i == ~acc_base_i) ? RES_PASS : RES_FAIL;
         end else begin
            res = RES_TXCK;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cks_o     <= '0;
         cks_vld_o <= 1'b0;
         pass_o    <= 1'b0;
         fail_o    <= 1'b0;
         len_err_o <= 1'b0;
      end else begin
         cks_vld_o <= (res == RES_TXCK);
         pass_o    <= (res == RES_PASS);
         fail_o    <= (res == RES_FAIL);
         len_err_o <= (res == RES_LENERR);
         if (res == RES_TXCK) begin
            cks_o <= ~sum_add_i;
         end
      end
   end

   // R10: never two result pulses together
   p_one_result_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cks_vld_o, pass_o, fail_o, len_err_o}));

   // R3: any result follows a closing byte by exactly one cycle
   p_result_cause_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cks_vld_o || pass_o || fail_o || len_err_o) |-> $past(fin_i));

   // R6: all-ones sum with a received all-ones byte is rejected
   p_ff_reject_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (fin_i && rx_i && !len_bad_i && acc_base_i == '1 && byte_i == '1) |=> fail_o);

endmodule

// File: rtl/lin_cksum_unit.sv
module lin_cksum_unit #(
   parameter int W         = 8,
   parameter int MAX_BYTES = 8,
   parameter int FOLD_SEL  = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start_i,
   input  logic         enh_mode_i,
   input  logic         rx_dir_i,
   input  logic [W-1:0] pid_i,
   input  logic         byte_vld_i,
   input  logic         byte_last_i,
   input  logic [W-1:0] byte_i,
   output logic [W-1:0] cks_o,
   output logic         cks_vld_o,
   output logic         pass_o,
   output logic         fail_o,
   output logic         len_err_o
);

   localparam int CNT_W = $clog2(MAX_BYTES + 2);

   logic         add_en;
   logic         fin;
   logic         rx_eff;
   logic         len_bad;
   logic [W-1:0] acc_base;
   logic [W-1:0] sum_add;

   lin_cks_ctl #(
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (CNT_W)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (frame_start_i),
      .rx_i      (rx_dir_i),
      .vld_i     (byte_vld_i),
      .last_i    (byte_last_i),
      .add_en_o  (add_en),
      .fin_o     (fin),
      .rx_eff_o  (rx_eff),
      .len_bad_o (len_bad)
   );

   lin_cks_accum #(
      .W        (W),
      .FOLD_SEL (FOLD_SEL)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (frame_start_i),
      .enh_i      (enh_mode_i),
      .pid_i      (pid_i),
      .add_en_i   (add_en),
      .byte_i     (byte_i),
      .acc_base_o (acc_base),
      .sum_add_o  (sum_add)
   );

   lin_cks_result #(
      .W (W)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .fin_i      (fin),
      .rx_i       (rx_eff),
      .len_bad_i  (len_bad),
      .acc_base_i (acc_base),
      .sum_add_i  (sum_add),
      .byte_i     (byte_i),
      .cks_o      (cks_o),
      .cks_vld_o  (cks_vld_o),
      .pass_o     (pass_o),
      .fail_o     (fail_o),
      .len_err_o  (len_err_o)
   );

endmodule

// File: tb/lin_cksum_unit_tb.sv
module lin_cksum_unit_tb;

   localparam int MAXB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start_i = 1'b0;
   logic       enh_mode_i = 1'b0;
   logic       rx_dir_i = 1'b0;
   logic [7:0] pid_i = 8'h00;
   logic       byte_vld_i = 1'b0;
   logic       byte_last_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic [7:0] cks_o;
   logic       cks_vld_o, pass_o, fail_o, len_err_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   lin_cksum_unit u_dut (
      .clk (clk), .rst_n (rst_n), .frame_start_i (frame_start_i),
      .enh_mode_i (enh_mode_i), .rx_dir_i (rx_dir_i), .pid_i (pid_i),
      .byte_vld_i (byte_vld_i), .byte_last_i (byte_last_i), .byte_i (byte_i),
      .cks_o (cks_o), .cks_vld_o (cks_vld_o), .pass_o (pass_o),
      .fail_o (fail_o), .len_err_o (len_err_o)
   );

   // ---------------- behavioural reference ----------------
   int m_open = 0, m_rx = 0, m_sum = 0, m_cnt = 0;
   int e_cks = 0, e_vld = 0, e_pass = 0, e_fail = 0, e_len = 0;

   function automatic int fold(input int a, input int b);
      int s;
      s = a + b;
      if (s > 255) s = s - 255;
      return s;
   endfunction

   always @(posedge clk) begin
      e_vld = 0; e_pass = 0; e_fail = 0; e_len = 0;
      if (!rst_n) begin
         m_open = 0; m_rx = 0; m_sum = 0; m_cnt = 0; e_cks = 0;
      end else begin
         if (frame_start_i) begin
            m_open = 1; m_rx = rx_dir_i; m_cnt = 0;
            m_sum = enh_mode_i ? int'(pid_i) : 0;
         end
         if (byte_vld_i && m_open != 0) begin
            if (byte_last_i && m_rx != 0) begin
               if (m_cnt == 0 || m_cnt > MAXB) e_len = 1;
               else if (int'(byte_i) == (255 - m_sum)) e_pass = 1;
               else e_fail = 1;
            end else begin
               m_sum = fold(m_sum, int'(byte_i));
               m_cnt = m_cnt + 1;
               if (byte_last_i) begin
                  if (m_cnt > MAXB) e_len = 1;
                  else begin e_vld = 1; e_cks = 255 - m_sum; end
               end
            end
            if (byte_last_i) m_open = 0;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   bit model_on = 0;
   always @(negedge clk) begin
      if (model_on && rst_n) begin
         chk({cur_req, " cks_o"},     int'(cks_o),     e_cks);
         chk({cur_req, " cks_vld_o"}, int'(cks_vld_o), e_vld);
         chk({cur_req, " pass_o"},    int'(pass_o),    e_pass);
         chk({cur_req, " fail_o"},    int'(fail_o),    e_fail);
         chk({cur_req, " len_err_o"}, int'(len_err_o), e_len);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   logic [7:0] q[$];

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_start_i = 0; byte_vld_i = 0; byte_last_i = 0;
      end
   endtask

   // Sends q; returns at the negedge where the result is visible
   task automatic send(input bit enh, input bit rx, input logic [7:0] pid,
                       input bit same_cycle, input bit flip);
      enh_mode_i = enh; rx_dir_i = rx; pid_i = pid;
      if (!same_cycle) begin
         @(negedge clk);
         frame_start_i = 1; byte_vld_i = 0; byte_last_i = 0;
      end
      for (int i = 0; i < q.size(); i++) begin
         @(negedge clk);
         frame_start_i = (same_cycle && i == 0);
         byte_vld_i = 1; byte_i = q[i]; byte_last_i = (i == q.size() - 1);
         if (flip && i == 1) begin
            enh_mode_i = ~enh; rx_dir_i = ~rx; pid_i = ~pid;
         end
      end
      @(negedge clk);
      frame_start_i = 0; byte_vld_i = 0; byte_last_i = 0;
   endtask

   function automatic int qsum(input int seed);
      int s = seed;
      foreach (q[i]) s = fold(s, int'(q[i]));
      return s;
   endfunction

   initial begin
      int sum0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 cks_o", int'(cks_o), 0);
      chk("R1 pulses", int'({cks_vld_o, pass_o, fail_o, len_err_o}), 0);
      rst_n = 1;
      model_on = 1;
      idle(2);

      // R2/R3: end-around carry, 0xF0+0x20 -> 0x11, checksum 0xEE
      cur_req = "R2";
      q = '{8'hF0, 8'h20};
      send(0, 0, 8'h00, 0, 0);
      chk("R3 cks_vld_o", int'(cks_vld_o), 1);
      chk("R2 cks_o", int'(cks_o), 8'hEE);
      idle(1);
      chk("R3 single pulse", int'(cks_vld_o), 0);
      chk("R3 cks_o held", int'(cks_o), 8'hEE);

      // R4: enhanced with identifier 0x06 sums to 0xFF -> 0x00; classic -> 0x06
      cur_req = "R4";
      q = '{8'h2C, 8'h3A, 8'h93, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      send(1, 0, 8'h06, 0, 0);
      chk("R4 enhanced cks_o", int'(cks_o), 8'h00);
      send(0, 0, 8'h06, 1, 0);
      chk("R4 classic cks_o", int'(cks_o), 8'h06);

      // R6: all-ones sum with received 0xFF must fail
      cur_req = "R6";
      q = '{8'h2C, 8'h3A, 8'h93, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
      send(1, 1, 8'h06, 0, 0);
      chk("R6 fail_o", int'(fail_o), 1);
      chk("R6 pass_o", int'(pass_o), 0);
      // R5: correct 0x00 passes
      cur_req = "R5";
      q[8] = 8'h00;
      send(1, 1, 8'h06, 1, 0);
      chk("R5 pass_o", int'(pass_o), 1);

      // R7: length limits
      cur_req = "R7";
      q = '{8'h55};
      send(0, 1, 8'h00, 0, 0);
      chk("R7 rx zero data", int'(len_err_o), 1);
      q = {};
      for (int i = 0; i < MAXB + 1; i++) q.push_back(8'(i + 1));
      send(0, 0, 8'h00, 0, 0);
      chk("R7 tx nine bytes", int'(len_err_o), 1);
      chk("R7 tx no cks", int'(cks_vld_o), 0);
      q.push_back(8'h00);
      send(0, 1, 8'h00, 0, 0);
      chk("R7 rx nine data", int'(len_err_o), 1);
      q = {};
      for (int i = 0; i < MAXB; i++) q.push_back(8'(8'h31 * (i + 1)));
      sum0 = qsum(0);
      q.push_back(8'(255 - sum0));
      send(0, 1, 8'h00, 0, 0);
      chk("R7 rx eight data pass", int'(pass_o), 1);

      // R8: mode, direction and identifier changes mid-frame are ignored
      cur_req = "R8";
      q = '{8'h10, 8'h20, 8'h30};
      send(1, 0, 8'h40, 0, 1);
      chk("R8 still transmit", int'(cks_vld_o), 1);
      chk("R8 cks_o", int'(cks_o), 8'h5F);

      // R9: stray bytes with no frame open
      cur_req = "R9";
      @(negedge clk);
      byte_vld_i = 1; byte_i = 8'h77; byte_last_i = 1;
      @(negedge clk);
      byte_vld_i = 0; byte_last_i = 0;
      chk("R9 no result", int'({cks_vld_o, pass_o, fail_o, len_err_o}), 0);
      chk("R9 cks_o unchanged", int'(cks_o), 8'h5F);

      // R10: start with a single closing byte, and restart inside an open frame
      cur_req = "R10";
      q = '{8'hFE};
      send(0, 0, 8'h00, 1, 0);
      chk("R10 same-cycle start", int'(cks_o), 8'h01);
      @(negedge clk);
      frame_start_i = 1; enh_mode_i = 0; rx_dir_i = 0;
      byte_vld_i = 1; byte_i = 8'h99; byte_last_i = 0;
      q = '{8'h01, 8'h02};
      send(0, 0, 8'h00, 1, 0);
      chk("R10 restart drops old bytes", int'(cks_o), 8'hFC);

      // random traffic judged by the model every cycle
      cur_req = "R10 random";
      for (int f = 0; f < 400; f++) begin
         bit rx, enh;
         int n;
         rx  = 1'($urandom_range(0, 1));
         enh = 1'($urandom_range(0, 1));
         n   = rx ? $urandom_range(0, MAXB + 2) : $urandom_range(1, MAXB + 2);
         q = {};
         for (int i = 0; i < n; i++) q.push_back(8'($urandom_range(0, 255)));
         if (rx) begin
            int ck;
            ck = 255 - qsum(0);
            if (enh) ck = 255 - fold(qsum(0), int'(pid_i));
            q.push_back(($urandom_range(0, 9) < 7) ? 8'(ck) : 8'($urandom_range(0, 255)));
         end
         // pid used for expected value above is the one driven below
         send(enh, rx, pid_i, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         pid_i = 8'($urandom_range(0, 255));
         idle($urandom_range(0, 2));
      end

      idle(3);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule